// File: doc/BRIEF.md
# Energy Efficient Ethernet Low-Power-Idle Controller

This block decides when a MAC transmit path may send the low-power-idle (LPI) pattern and when it must come back. Software programs a control/status word and a timer word through a small register port. The block only lets LPI start after the software-written link-good bit has held long enough, measured in milliseconds. After LPI ends, it holds off normal transmission for a programmed wake time, measured in microseconds. A tick generator derives both time units from a cycle count per microsecond.

There are two ways to enter LPI. In software-directed mode the path enters LPI whenever it is idle and leaves only when software or the link says so. In automatic mode a new frame request also ends LPI. The block also watches the receive-side LPI indication from the PHY. Entry and exit on both sides are latched in sticky flags that clear when the control/status word is read, and any latched flag can raise one maskable interrupt. The transmit clock may optionally be gated while the path sits in LPI.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: Register 1 (timer) holds the wake time in bits [15:0] (microseconds) and the link-stable time in bits [25:16] (milliseconds). It resets to 0, and bits [31:26] always read 0.
- R2: A microsecond tick occurs once every CYC_PER_US cycles, counted from reset. A millisecond tick occurs on every US_PER_MS-th microsecond tick.
- R3: While the link-good bit (register 0 bit 2) is 1, a counter advances on millisecond ticks. The link counts as stable only once this counter exceeds the link-stable time. This guarantees at least that many whole milliseconds before any LPI entry.
- R4: From the active state, lpi_tx rises one cycle after a cycle in which all of the following hold: either the enable bit (bit 0) or the automatic bit (bit 1) is set, the link is stable, tx_idle is 1, and tx_req is 0.
- R5: In automatic mode a tx_req of 1 during LPI starts an exit. With only the enable bit set, tx_req does not end LPI.
- R6: If both the enable and automatic bits are 0 while in LPI, lpi_tx falls on the next cycle.
- R7: After every LPI exit, tx_hold stays 1 until more microsecond ticks than the wake time have been counted. Only then does the path return to active and tx_hold fall. tx_hold is also 1 during LPI.
- R8: Clearing the link-good bit resets the link counter to zero, which ends LPI. A new entry then needs the full link-stable time again.
- R9: tx_clk_gate_en is 1 exactly while lpi_tx is 1 and the gate bit (bit 3) is set.
- R10: Register 0 bits [11:8] are sticky flags: bit 8 transmit entry, bit 9 transmit exit, bit 10 receive entry, bit 11 receive exit. A read of register 0 returns them and then clears them. An event in the same cycle as the read stays set.
- R11: A rise of phy_rx_lpi sets the receive-entry flag and a fall sets the receive-exit flag. Register 0 bit 17 shows the sampled receive LPI state.
- R12: lpi_irq is 1 exactly when the interrupt-enable bit (bit 4) is set and at least one flag is set.
- R13: Register 0 reads back bits 0 to 4 as written and bit 16 as the transmit LPI state. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags for register 0) |
| reg_addr | input | 1 | 0 = control/status, 1 = timer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_idle | input | 1 | MAC transmit path is idle |
| tx_req | input | 1 | A frame is pending for transmission |
| phy_rx_lpi | input | 1 | Receive side is in LPI |
| lpi_tx | output | 1 | Request to send the LPI pattern |
| tx_clk_gate_en | output | 1 | Transmit clock may be gated |
| tx_hold | output | 1 | Normal transmission not allowed (LPI or wake wait) |
| lpi_irq | output | 1 | LPI event interrupt |

## Verification
The bench builds the block with CYC_PER_US = 4 and US_PER_MS = 5, so a millisecond lasts 20 cycles. This puts link-stable times of a few milliseconds and wake times of a few microseconds within a few dozen cycles. With those values, the partial first tick after a link rise or an exit, the saturation of both counters, and repeated entry and exit cycles all fit in a short run. A behavioural model running alongside tracks every cycle of that timing.

// File: rtl/eee_lpi_pkg.sv
// Shared types and register field positions for the LPI controller.
// Assumes one clock domain for all users.
package eee_lpi_pkg;

    // Transmit path state
    typedef enum logic [1:0] {
        TX_ACTIVE = 2'd0,
        TX_LPI    = 2'd1,
        TX_WAKE   = 2'd2
    } tx_state_t;

    localparam int WAKE_W = 16;
    localparam int LINK_W = 10;
    localparam int FLAG_N = 4;

    // Control/status word fields
    localparam int CS_EN    = 0;
    localparam int CS_AUTO  = 1;
    localparam int CS_LINK  = 2;
    localparam int CS_GATE  = 3;
    localparam int CS_IE    = 4;
    localparam int CS_FLAGS = 8;
    localparam int CS_TXST  = 16;
    localparam int CS_RXST  = 17;

    // Timer word fields
    localparam int TM_WAKE = 0;
    localparam int TM_LINK = 16;

    // Flag indices
    localparam int FL_TX_IN  = 0;
    localparam int FL_TX_OUT = 1;
    localparam int FL_RX_IN  = 2;
    localparam int FL_RX_OUT = 3;

endpackage

// File: rtl/eee_tick_gen.sv
// Microsecond and millisecond tick generator (R2).
// Free-running from reset; us_tick pulses once per CYC_PER_US cycles,
// ms_tick pulses on every US_PER_MS-th us_tick. Assumes both params >= 1.
module eee_tick_gen #(
    parameter int CYC_PER_US = 250,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick,
    output logic ms_tick
);
    localparam int PW = $clog2(CYC_PER_US + 1);
    localparam int MW = $clog2(US_PER_MS + 1);

    logic [PW-1:0] pre_q;
    logic [MW-1:0] us_q;

    assign us_tick = (pre_q == PW'(CYC_PER_US - 1));
    assign ms_tick = us_tick && (us_q == MW'(US_PER_MS - 1));

    // Cycle prescaler wrapping at one microsecond
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (us_tick) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    // Microsecond counter wrapping at one millisecond
    always_ff @(posedge clk) begin
        if (!rst_n)       us_q <= '0;
        else if (ms_tick) us_q <= '0;
        else if (us_tick) us_q <= us_q + 1'b1;
    end
endmodule

// File: rtl/eee_link_timer.sv
// Link-stable timer (R3, R8).
// Counts millisecond ticks while link_up is 1 and clears at once when it
// drops. Saturates one above link_time; link_ok once the count exceeds it.
module eee_link_timer #(
    parameter int LINK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              ms_tick,
    input  logic [LINK_W-1:0] link_time,
    output logic              link_ok
);
    logic [LINK_W:0] cnt_q;

    assign link_ok = (cnt_q > {1'b0, link_time});

    // Millisecond count of continuous good link
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!link_up)            cnt_q <= '0;
        else if (ms_tick && !link_ok) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/eee_tx_fsm.sv
// Transmit LPI state machine with wake-time counter (R4-R8).
// Enters LPI from active when allowed and idle; leaves on forced exit,
// link loss, or a frame request in automatic mode; then waits more than
// wake_time microsecond ticks before returning to active.
module eee_tx_fsm
    import eee_lpi_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          mode_auto,
    input  logic          link_ok,
    input  logic          tx_idle,
    input  logic          tx_req,
    input  logic          us_tick,
    input  logic [WW-1:0] wake_time,
    output tx_state_t     state,
    output logic          ev_enter,
    output logic          ev_leave
);
    tx_state_t   nxt;
    logic [WW:0] wcnt_q;
    logic        wake_done;
    logic        allowed;

    assign allowed   = mode_en || mode_auto;
    assign wake_done = (wcnt_q > {1'b0, wake_time});

    // Next-state and event decode
    always_comb begin
        nxt      = state;
        ev_enter = 1'b0;
        ev_leave = 1'b0;
        unique case (state)
            TX_ACTIVE: if (allowed && link_ok && tx_idle && !tx_req) begin
                nxt      = TX_LPI;
                ev_enter = 1'b1;
            end
            TX_LPI: if (!allowed || !link_ok || (mode_auto && tx_req)) begin
                nxt      = TX_WAKE;
                ev_leave = 1'b1;
            end
            TX_WAKE: if (wake_done) nxt = TX_ACTIVE;
            default: nxt = TX_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_ACTIVE;
        else        state <= nxt;
    end

    // Wake-time microsecond counter, cleared outside the wake wait
    always_ff @(posedge clk) begin
        if (!rst_n)                     wcnt_q <= '0;
        else if (state != TX_WAKE)      wcnt_q <= '0;
        else if (us_tick && !wake_done) wcnt_q <= wcnt_q + 1'b1;
    end
endmodule

// File: rtl/eee_event_flags.sv
// Sticky event flags (R10).
// Each flag sets on its event pulse and clears on clr; a set in the
// same cycle as clr wins so no event is lost.
module eee_event_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag bit
        always_ff @(posedge clk) begin
            if (!rst_n)     flags[i] <= 1'b0;
            else if (ev[i]) flags[i] <= 1'b1;
            else if (clr)   flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/eee_lpi_ctrl.sv
// Energy Efficient Ethernet LPI controller top.
// Holds the control/status and timer words, samples the receive LPI
// indication, and ties the tick generator, link timer, transmit state
// machine and event flags together. Assumes all inputs are in clk's domain.
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int US_PER_MS  = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_idle,
    input  logic        tx_req,
    input  logic        phy_rx_lpi,
    output logic        lpi_tx,
    output logic        tx_clk_gate_en,
    output logic        tx_hold,
    output logic        lpi_irq
);
    logic              ctl_en, ctl_auto, ctl_link, ctl_gate, ctl_ie;
    logic [WAKE_W-1:0] wake_time;
    logic [LINK_W-1:0] link_time;
    logic              us_tick, ms_tick, link_ok;
    logic              rx_q;
    logic              ev_enter, ev_leave;
    logic [FLAG_N-1:0] events, flags;
    logic              flag_clr;
    tx_state_t         tx_st;
    logic              wdata_unused;

    assign wdata_unused = ^{reg_wdata[31:26], reg_wdata[7:5]};

    // Control word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_auto <= 1'b0;
            ctl_link <= 1'b0;
            ctl_gate <= 1'b0;
            ctl_ie   <= 1'b0;
        end else if (reg_wr && !reg_addr) begin
            ctl_en   <= reg_wdata[CS_EN];
            ctl_auto <= reg_wdata[CS_AUTO];
            ctl_link <= reg_wdata[CS_LINK];
            ctl_gate <= reg_wdata[CS_GATE];
            ctl_ie   <= reg_wdata[CS_IE];
        end
    end

    // Timer word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_time <= '0;
            link_time <= '0;
        end else if (reg_wr && reg_addr) begin
            wake_time <= reg_wdata[TM_WAKE +: WAKE_W];
            link_time <= reg_wdata[TM_LINK +: LINK_W];
        end
    end

    // Receive LPI sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b0;
        else        rx_q <= phy_rx_lpi;
    end

    eee_tick_gen #(.CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS)) i_tick (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick)
    );

    eee_link_timer #(.LINK_W(LINK_W)) i_link (
        .clk(clk), .rst_n(rst_n), .link_up(ctl_link), .ms_tick(ms_tick),
        .link_time(link_time), .link_ok(link_ok)
    );

    eee_tx_fsm #(.WW(WAKE_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .mode_en(ctl_en), .mode_auto(ctl_auto),
        .link_ok(link_ok), .tx_idle(tx_idle), .tx_req(tx_req),
        .us_tick(us_tick), .wake_time(wake_time), .state(tx_st),
        .ev_enter(ev_enter), .ev_leave(ev_leave)
    );

    // Event vector in flag order
    always_comb begin
        events            = '0;
        events[FL_TX_IN]  = ev_enter;
        events[FL_TX_OUT] = ev_leave;
        events[FL_RX_IN]  = phy_rx_lpi && !rx_q;
        events[FL_RX_OUT] = !phy_rx_lpi && rx_q;
    end

    assign flag_clr = reg_rd && !reg_addr;

    eee_event_flags #(.N(FLAG_N)) i_flags (
        .clk(clk), .rst_n(rst_n), .ev(events), .clr(flag_clr), .flags(flags)
    );

    assign lpi_tx         = (tx_st == TX_LPI);
    assign tx_hold        = (tx_st != TX_ACTIVE);
    assign tx_clk_gate_en = lpi_tx && ctl_gate;
    assign lpi_irq        = ctl_ie && (|flags);

    // Read data mux
    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[CS_EN]                = ctl_en;
            reg_rdata[CS_AUTO]              = ctl_auto;
            reg_rdata[CS_LINK]              = ctl_link;
            reg_rdata[CS_GATE]              = ctl_gate;
            reg_rdata[CS_IE]                = ctl_ie;
            reg_rdata[CS_FLAGS +: FLAG_N]   = flags;
            reg_rdata[CS_TXST]              = lpi_tx;
            reg_rdata[CS_RXST]              = rx_q;
        end else begin
            reg_rdata[TM_WAKE +: WAKE_W]    = wake_time;
            reg_rdata[TM_LINK +: LINK_W]    = link_time;
        end
    end
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
// Property checker for the LPI controller, bound into the top.
// Relates port behaviour to internal link, control and flag state.
module eee_lpi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lpi_tx,
    input logic       tx_hold,
    input logic       tx_clk_gate_en,
    input logic       tx_idle,
    input logic       tx_req,
    input logic       link_ok,
    input logic       ctl_en,
    input logic       ctl_auto,
    input logic [3:0] flags
);
    a_r3_entry_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_tx) |-> $past(link_ok));

    a_r4_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_tx) |-> ($past(tx_idle) && !$past(tx_req)));

    a_r6_forced_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_tx && !ctl_en && !ctl_auto) |=> !lpi_tx);

    a_r7_wake_follows_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpi_tx) |-> tx_hold);

    a_r8_link_loss_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_tx && !link_ok) |=> !lpi_tx);

    a_r9_gate_only_in_lpi: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_gate_en |-> lpi_tx);

    a_r10_entry_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_tx) |-> flags[0]);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .lpi_tx(lpi_tx), .tx_hold(tx_hold),
    .tx_clk_gate_en(tx_clk_gate_en), .tx_idle(tx_idle), .tx_req(tx_req),
    .link_ok(link_ok), .ctl_en(ctl_en), .ctl_auto(ctl_auto), .flags(flags)
);

// File: tb/test_eee_lpi_ctrl.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module test_eee_lpi_ctrl;
    localparam int CYC = 4;
    localparam int UPM = 5;
    localparam int TW  = 3;
    localparam int LS  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_idle = 1'b0, tx_req = 1'b0, phy_rx_lpi = 1'b0;
    logic        lpi_tx, tx_clk_gate_en, tx_hold, lpi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eee_lpi_ctrl #(.CYC_PER_US(CYC), .US_PER_MS(UPM)) i_eee_lpi_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_idle(tx_idle), .tx_req(tx_req), .phy_rx_lpi(phy_rx_lpi),
        .lpi_tx(lpi_tx), .tx_clk_gate_en(tx_clk_gate_en),
        .tx_hold(tx_hold), .lpi_irq(lpi_irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_pre, m_us, m_lcnt, m_st, m_wc, m_flags, m_rxq;
    int m_en, m_auto, m_link, m_gate, m_ie, m_tw, m_ls;

    function automatic int m_rdata(input logic a);
        if (a) return m_tw | (m_ls << 16);
        return m_en | (m_auto << 1) | (m_link << 2) | (m_gate << 3) | (m_ie << 4)
             | (m_flags << 8) | ((m_st == 1) << 16) | (m_rxq << 17);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_us = 0; m_lcnt = 0; m_st = 0; m_wc = 0; m_flags = 0; m_rxq = 0;
            m_en = 0; m_auto = 0; m_link = 0; m_gate = 0; m_ie = 0; m_tw = 0; m_ls = 0;
        end else begin
            bit ut, mt, lok, allow;
            int ev, nst;
            ut    = (m_pre == CYC - 1);
            mt    = ut && (m_us == UPM - 1);
            lok   = (m_lcnt > m_ls);
            allow = (m_en != 0) || (m_auto != 0);
            ev    = 0;
            nst   = m_st;
            if (m_st == 0) begin
                if (allow && lok && tx_idle && !tx_req) begin nst = 1; ev |= 1; end
            end else if (m_st == 1) begin
                if (!allow || !lok || (m_auto != 0 && tx_req)) begin nst = 2; ev |= 2; end
            end else if (m_wc > m_tw) nst = 0;
            if (m_st != 2) m_wc = 0;
            else if (ut && !(m_wc > m_tw)) m_wc++;
            m_st = nst;
            if (m_link == 0) m_lcnt = 0;
            else if (mt && !lok) m_lcnt++;
            m_pre = ut ? 0 : m_pre + 1;
            if (ut) m_us = mt ? 0 : m_us + 1;
            if (phy_rx_lpi && m_rxq == 0) ev |= 4;
            if (!phy_rx_lpi && m_rxq != 0) ev |= 8;
            m_rxq = phy_rx_lpi;
            if (reg_rd && !reg_addr) m_flags = 0;
            m_flags |= ev;
            if (reg_wr && !reg_addr) begin
                m_en = reg_wdata[0]; m_auto = reg_wdata[1]; m_link = reg_wdata[2];
                m_gate = reg_wdata[3]; m_ie = reg_wdata[4];
            end
            if (reg_wr && reg_addr) begin
                m_tw = reg_wdata[15:0]; m_ls = reg_wdata[25:16];
            end
        end
        #1;
        if (rst_n && !done) begin
            chk(lpi_tx == (m_st == 1), "R4 lpi_tx vs model", lpi_tx, m_st == 1);
            chk(tx_hold == (m_st != 0), "R7 tx_hold vs model", tx_hold, m_st != 0);
            chk(tx_clk_gate_en == (m_st == 1 && m_gate != 0), "R9 gate vs model",
                tx_clk_gate_en, m_st == 1 && m_gate != 0);
            chk(lpi_irq == (m_ie != 0 && m_flags != 0), "R12 irq vs model",
                lpi_irq, m_ie != 0 && m_flags != 0);
            chk(reg_rdata == 32'(m_rdata(reg_addr)), "R13 rdata vs model",
                reg_rdata, m_rdata(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd0(output logic [31:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b0;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [31:0] v);
        @(negedge clk); reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk); reg_addr = 1'b0;
    endtask

    task automatic wait_lpi(input logic val, output int n);
        n = 0;
        while (lpi_tx !== val && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_active(output int n);
        n = 0;
        while (tx_hold !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R13, R1)
        peek(1'b0, v); chk(v == 0, "R13 ctrl reset", v, 0);
        peek(1'b1, v); chk(v == 0, "R1 timer reset", v, 0);
        chk(!lpi_tx && !tx_hold && !lpi_irq, "R13 outputs reset", {lpi_tx, tx_hold, lpi_irq}, 0);

        // Timer field width (R1)
        wr(1'b1, 32'hFFFF_FFFF);
        peek(1'b1, v); chk(v == 32'h03FF_FFFF, "R1 timer upper bits zero", v, 32'h03FF_FFFF);
        wr(1'b1, (LS << 16) | TW);
        peek(1'b1, v); chk(v == ((LS << 16) | TW), "R1 timer fields", v, (LS << 16) | TW);

        // Automatic entry after link-stable time (R3, R4)
        tx_idle = 1'b1;
        wr(1'b0, 32'h1E);
        wait_lpi(1'b1, n);
        chk(lpi_tx == 1'b1, "R4 auto entry", lpi_tx, 1);
        chk(n + 1 >= LS * UPM * CYC, "R3 link-stable delay", n, LS * UPM * CYC);
        chk(tx_clk_gate_en == 1'b1, "R9 gate on in lpi", tx_clk_gate_en, 1);
        chk(lpi_irq == 1'b1, "R12 irq on entry", lpi_irq, 1);
        rd0(v);
        chk(v[8] && v[16], "R10 entry flag and state bit", v, 32'h0001_0100 | 32'h1E);
        @(negedge clk);
        chk(lpi_irq == 1'b0, "R10 read clears flags", lpi_irq, 0);

        // Frame request in automatic mode exits, then wake time (R5, R7, R2)
        tx_req = 1'b1;
        @(negedge clk);
        chk(!lpi_tx && tx_hold, "R5 auto exit on tx_req", {lpi_tx, tx_hold}, 1);
        wait_active(n);
        chk(n >= TW * CYC - 1 && n <= (TW + 1) * CYC + 2, "R2 R7 wake duration", n, TW * CYC);
        tx_req = 1'b0;
        wait_lpi(1'b1, n);
        chk(lpi_tx == 1'b1, "R4 re-entry when request clears", lpi_tx, 1);

        // Software-directed mode ignores tx_req (R5, R9)
        wr(1'b0, 32'h15);
        chk(lpi_tx && !tx_clk_gate_en, "R9 gate off with bit clear", {lpi_tx, tx_clk_gate_en}, 2);
        tx_req = 1'b1;
        repeat (10) @(negedge clk);
        chk(lpi_tx == 1'b1, "R5 manual mode holds lpi", lpi_tx, 1);
        tx_req = 1'b0;

        // Forced exit (R6)
        wr(1'b0, 32'h14);
        @(negedge clk);
        chk(lpi_tx == 1'b0 && tx_hold, "R6 forced exit", {lpi_tx, tx_hold}, 1);
        wait_active(n);

        // Link drop aborts and restarts the link timer (R8)
        wr(1'b0, 32'h16);
        wait_lpi(1'b1, n);
        wr(1'b0, 32'h12);
        @(negedge clk); @(negedge clk);
        chk(lpi_tx == 1'b0, "R8 link drop exits", lpi_tx, 0);
        wr(1'b0, 32'h16);
        wait_lpi(1'b1, n);
        chk(lpi_tx == 1'b1 && n + 1 >= LS * UPM * CYC, "R8 timer restarted", n, LS * UPM * CYC);

        // Receive side events (R11, R10)
        rd0(v);
        phy_rx_lpi = 1'b1;
        repeat (3) @(negedge clk);
        rd0(v);
        chk(v[10] && v[17] && !v[11], "R11 rx entry flag and state", v[17:8], 10'h204);
        phy_rx_lpi = 1'b0;
        repeat (2) @(negedge clk);
        rd0(v);
        chk(v[11] && !v[10] && !v[17], "R11 rx exit flag", v[17:8], 10'h008);
        @(negedge clk); phy_rx_lpi = 1'b1; reg_rd = 1'b1; reg_addr = 1'b0;
        @(negedge clk); reg_rd = 1'b0;
        peek(1'b0, v);
        chk(v[10] == 1'b1, "R10 set wins over read clear", v[10], 1);

        // Interrupt mask (R12)
        rd0(v);
        wr(1'b0, 32'h06);
        phy_rx_lpi = 1'b0;
        repeat (2) @(negedge clk);
        chk(lpi_irq == 1'b0, "R12 irq masked", lpi_irq, 0);
        wr(1'b0, 32'h16);
        chk(lpi_irq == 1'b1, "R12 irq unmasked", lpi_irq, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule